// File: doc/BRIEF.md
# Selectable Line Codec (NRZ, NRZI, FM1, FM0)

This block turns a serial bit stream into line levels and back, using one of four line codes picked at run time by a two-bit mode input. The same mode value steers the transmit encoder and the receive decoder. The codec runs at one clock per bit. The surrounding logic supplies explicit single-cycle strobes: the start of each transmit bit cell, the middle of each transmit cell (used only by the bi-phase codes), and one or two receive sample points per cell. Clock recovery, sync detection and CRC are not part of this block.

The transmit side is a valid/ready sink. `tx_ready` is high only in a cycle where `tx_cell_stb` is high, and a bit moves when `tx_valid` and `tx_ready` are both high. The source must hold `tx_bit` and `tx_valid` steady until that cycle. If no bit is offered at a cell start, the encoder sends an idle mark bit (1) for that cell. The receive side is a push-only source. The line cannot be stalled, so `rx_valid` has no ready, and the consumer must take `rx_bit` in the cycle `rx_valid` is high.

Each path samples the mode at its own bit boundary: the cell strobe for transmit and the first sample strobe for receive. A mode change part-way through a cell therefore applies from the next cell on.

Top module: `line_codec_xcvr`

## Requirements
- R1: Mode code 2'b00 selects NRZ, 2'b01 NRZI, 2'b10 FM1 and 2'b11 FM0. After reset the held mode is NRZ, `tx_line` is high, `tx_ready` is low when no strobe is present, and `rx_valid` is low.
- R2: In NRZ mode, `tx_line` takes the level of the accepted bit one cycle after `tx_cell_stb`.
- R3: In NRZI mode, a 0 bit inverts `tx_line` one cycle after `tx_cell_stb` and a 1 bit leaves it unchanged. The line level before the first cell is high.
- R4: In FM1 and FM0 modes, `tx_line` inverts one cycle after every `tx_cell_stb`. It inverts again one cycle after `tx_mid_stb` when the bit is 1 (FM1) or 0 (FM0), and otherwise holds.
- R5: `tx_ready` equals `tx_cell_stb`. A cell that starts with `tx_valid` low is encoded as a 1 bit.
- R6: In NRZ mode, `rx_bit` is the `rx_line` level sampled at `rx_first_stb`, and `rx_valid` pulses one cycle after that strobe.
- R7: In NRZI mode, `rx_bit` is 1 when the level at `rx_first_stb` equals the previously accepted sample, and 0 when it differs. The previous sample is high after reset.
- R8: In FM modes, `rx_first_stb` produces no output. At `rx_second_stb` the decoder compares the two half-cell samples: a difference yields 1 in FM1 and 0 in FM0, and equality yields the opposite. `rx_valid` pulses one cycle after `rx_second_stb`.
- R9: A change of `mode` after a cell has started leaves the encoding and decoding of that cell unchanged. The new mode applies from the next cell start on each path.
- R10: `tx_line` changes only in the cycle after a strobe. `tx_mid_stb` has no effect in NRZ and NRZI modes, `rx_second_stb` yields no output in those modes, and each bit cell produces exactly one `rx_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Line code select, shared by both paths |
| tx_valid | input | 1 | Transmit bit offered |
| tx_ready | output | 1 | Transmit bit accepted this cycle |
| tx_bit | input | 1 | Transmit data bit |
| tx_cell_stb | input | 1 | Start of transmit bit cell |
| tx_mid_stb | input | 1 | Middle of transmit bit cell (FM only) |
| tx_line | output | 1 | Encoded line level |
| rx_line | input | 1 | Received line level |
| rx_first_stb | input | 1 | Bit sample (NRZ/NRZI) or first-half sample (FM) |
| rx_second_stb | input | 1 | Second-half sample (FM only) |
| rx_bit | output | 1 | Decoded data bit |
| rx_valid | output | 1 | Decoded bit present, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a mode change that arrives in the middle of a cell. The transmitter has already decided on its mid-cell inversion, and the receiver has latched the mode with its first sample but has not yet compared the second one. The bench drives the encoder and the decoder as a loopback. Each cell can change `mode` after the first receive sample and before the mid-cell strobe, so both paths have to finish the cell under the old code while the next cell runs under the new one. The bench checks the line level in both halves of each cell against its own model of the chosen code, and it compares every decoded bit against a queue of the bits that were sent.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    LC_NRZ  = 2'b00,
    LC_NRZI = 2'b01,
    LC_FM1  = 2'b10,
    LC_FM0  = 2'b11
  } lc_mode_e;

  function automatic logic lc_is_fm(lc_mode_e m);
    return (m == LC_FM1) || (m == LC_FM0);
  endfunction

  // bi-phase: does this bit call for a mid-cell inversion
  function automatic logic lc_mid_flip(lc_mode_e m, logic b);
    return (m == LC_FM1) ? b : ~b;
  endfunction

endpackage

// File: rtl/lc_mode_hold.sv
module lc_mode_hold
  import lc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  lc_mode_e mode_in,
  output lc_mode_e mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    mode_q <= LC_NRZ;
    else if (load) mode_q <= mode_in;
  end

endmodule

// File: rtl/lc_tx_encoder.sv
module lc_tx_encoder
  import lc_pkg::*;
#(
  parameter logic REST_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cell_stb,
  input  logic     mid_stb,
  input  logic     sym,
  input  lc_mode_e mode_in,
  output logic     line
);

  logic line_q;
  logic mid_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q     <= REST_LEVEL;
      mid_pend_q <= 1'b0;
    end else if (cell_stb) begin
      unique case (mode_in)
        LC_NRZ:  line_q <= sym;
        LC_NRZI: line_q <= sym ? line_q : ~line_q;
        default: line_q <= ~line_q;
      endcase
      mid_pend_q <= lc_is_fm(mode_in) && lc_mid_flip(mode_in, sym);
    end else if (mid_stb && mid_pend_q) begin
      line_q     <= ~line_q;
      mid_pend_q <= 1'b0;
    end
  end

  assign line = line_q;

endmodule

// File: rtl/lc_rx_decoder.sv
module lc_rx_decoder
  import lc_pkg::*;
#(
  parameter logic REST_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     first_stb,
  input  logic     second_stb,
  input  logic     line_in,
  input  lc_mode_e mode_in,
  output logic     bit_out,
  output logic     valid_out
);

  lc_mode_e held_mode;
  logic     prev_q;
  logic     half1_q;
  logic     bit_q;
  logic     valid_q;

  lc_mode_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (first_stb),
    .mode_in(mode_in),
    .mode_q (held_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= REST_LEVEL;
      half1_q <= REST_LEVEL;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (first_stb) begin
        prev_q  <= line_in;
        half1_q <= line_in;
        unique case (mode_in)
          LC_NRZ: begin
            bit_q   <= line_in;
            valid_q <= 1'b1;
          end
          LC_NRZI: begin
            bit_q   <= (line_in == prev_q);
            valid_q <= 1'b1;
          end
          default: ;
        endcase
      end else if (second_stb && lc_is_fm(held_mode)) begin
        prev_q  <= line_in;
        bit_q   <= (half1_q != line_in) ^ (held_mode == LC_FM0);
        valid_q <= 1'b1;
      end
    end
  end

  assign bit_out   = bit_q;
  assign valid_out = valid_q;

endmodule

// File: rtl/line_codec_xcvr.sv
module line_codec_xcvr
  import lc_pkg::*;
#(
  parameter logic IDLE_BIT   = 1'b1,
  parameter logic REST_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic       tx_bit,
  input  logic       tx_cell_stb,
  input  logic       tx_mid_stb,
  output logic       tx_line,
  input  logic       rx_line,
  input  logic       rx_first_stb,
  input  logic       rx_second_stb,
  output logic       rx_bit,
  output logic       rx_valid
);

  lc_mode_e mode_e;
  logic     tx_sym;

  assign mode_e   = lc_mode_e'(mode);
  assign tx_ready = tx_cell_stb;
  assign tx_sym   = tx_valid ? tx_bit : IDLE_BIT;

  lc_tx_encoder #(.REST_LEVEL(REST_LEVEL)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cell_stb(tx_cell_stb),
    .mid_stb (tx_mid_stb),
    .sym     (tx_sym),
    .mode_in (mode_e),
    .line    (tx_line)
  );

  lc_rx_decoder #(.REST_LEVEL(REST_LEVEL)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_stb (rx_first_stb),
    .second_stb(rx_second_stb),
    .line_in   (rx_line),
    .mode_in   (mode_e),
    .bit_out   (rx_bit),
    .valid_out (rx_valid)
  );

endmodule

// File: rtl/lc_xcvr_checks.sv
module lc_xcvr_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       tx_valid,
  input logic       tx_bit,
  input logic       tx_cell_stb,
  input logic       tx_mid_stb,
  input logic       tx_line,
  input logic       rx_line,
  input logic       rx_first_stb,
  input logic       rx_second_stb,
  input logic       rx_bit,
  input logic       rx_valid
);

  p_nrz_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_stb && tx_valid && mode == 2'b00 |=> tx_line == $past(tx_bit));

  p_nrzi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_stb && tx_valid && tx_bit && mode == 2'b01 |=> $stable(tx_line));

  p_nrzi_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_stb && tx_valid && !tx_bit && mode == 2'b01 |=> tx_line != $past(tx_line));

  p_fm_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_stb && mode[1] |=> tx_line != $past(tx_line));

  p_idle_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_stb && !tx_valid && mode == 2'b00 |=> tx_line);

  p_rx_nrz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_first_stb && mode == 2'b00 |=> rx_valid && rx_bit == $past(rx_line));

  p_fm_first_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_first_stb && mode[1] |=> !rx_valid);

  p_line_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_cell_stb && !tx_mid_stb |=> $stable(tx_line));

  p_valid_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_first_stb || rx_second_stb));

endmodule

bind line_codec_xcvr lc_xcvr_checks u_chk (.*);

// File: tb/tb_line_codec_xcvr.sv
module tb_line_codec_xcvr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       tx_bit = 1'b0;
  logic       tx_cell_stb = 1'b0;
  logic       tx_mid_stb = 1'b0;
  logic       tx_line;
  logic       rx_line;
  logic       rx_first_stb = 1'b0;
  logic       rx_second_stb = 1'b0;
  logic       rx_bit;
  logic       rx_valid;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic lvl   = 1'b1;   // model of last line level
  logic exp_q[$];

  always #5 clk = ~clk;

  assign rx_line = tx_line;   // loopback

  line_codec_xcvr dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .tx_cell_stb(tx_cell_stb), .tx_mid_stb(tx_mid_stb), .tx_line(tx_line),
    .rx_line(rx_line), .rx_first_stb(rx_first_stb), .rx_second_stb(rx_second_stb),
    .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one bit cell of 8 cycles: mode m at the cell start, m_after from mid-cell on
  task automatic send(input logic [1:0] m, input logic b, input logic v, input logic [1:0] m_after);
    logic sym, h1, h2;
    sym = v ? b : 1'b1;
    case (m)
      2'b00: begin h1 = sym; h2 = sym; end
      2'b01: begin h1 = sym ? lvl : ~lvl; h2 = h1; end
      default: begin
        h1 = ~lvl;
        h2 = (((m == 2'b10) ? sym : ~sym) != 1'b0) ? ~h1 : h1;
      end
    endcase
    lvl = h2;
    exp_q.push_back(sym);
    @(negedge clk);
    mode = m; tx_valid = v; tx_bit = b; tx_cell_stb = 1'b1;
    #1 chk(tx_ready == 1'b1, "R5 ready on cell strobe", tx_ready, 1'b1);
    @(negedge clk);
    tx_cell_stb = 1'b0; tx_valid = 1'b0; tx_bit = ~b;
    @(negedge clk);
    chk(tx_line == h1, "R2/R3/R4 first-half level", tx_line, h1);
    rx_first_stb = 1'b1;
    @(negedge clk);
    rx_first_stb = 1'b0; mode = m_after;   // R9 mid-cell mode change
    @(negedge clk);
    tx_mid_stb = 1'b1;
    @(negedge clk);
    tx_mid_stb = 1'b0;
    @(negedge clk);
    chk(tx_line == h2, "R4/R9/R10 second-half level", tx_line, h2);
    rx_second_stb = 1'b1;
    @(negedge clk);
    rx_second_stb = 1'b0;
  endtask

  task automatic run_pattern(input logic [1:0] m, input logic [7:0] pat);
    for (int i = 0; i < 8; i++) send(m, pat[i], 1'b1, m);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 extra rx_valid", rx_bit, 1'bx);
      end else begin
        logic e;
        e = exp_q.pop_front();
        chk(rx_bit == e, "R6/R7/R8 decoded bit", rx_bit, e);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tx_line == 1'b1, "R1 reset line level", tx_line, 1'b1);
    chk(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1 line after reset", tx_line, 1'b1);
    chk(tx_ready == 1'b0, "R1 ready low without strobe", tx_ready, 1'b0);
    // R7 / R3: NRZI from reset, previous level is high
    run_pattern(2'b01, 8'b1000_1011);
    send(2'b01, 1'b0, 1'b0, 2'b01);          // R5 idle in NRZI
    run_pattern(2'b00, 8'b0110_0101);         // R2 R6
    send(2'b00, 1'b0, 1'b0, 2'b00);          // R5 idle mark
    run_pattern(2'b10, 8'b1000_1101);         // R4 R8 FM1
    send(2'b10, 1'b0, 1'b0, 2'b10);
    run_pattern(2'b11, 8'b0101_1010);         // R4 R8 FM0
    send(2'b11, 1'b1, 1'b0, 2'b11);
    // R9 mode changes mid-cell
    send(2'b00, 1'b1, 1'b1, 2'b10);
    send(2'b10, 1'b0, 1'b1, 2'b01);
    send(2'b01, 1'b0, 1'b1, 2'b11);
    send(2'b11, 1'b1, 1'b1, 2'b00);
    send(2'b00, 1'b0, 1'b1, 2'b11);
    send(2'b11, 1'b0, 1'b1, 2'b10);
    send(2'b10, 1'b1, 1'b1, 2'b00);
    send(2'b01, 1'b1, 1'b1, 2'b01);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 one rx_valid per cell", 1'(exp_q.size() != 0), 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule